// File: doc/BRIEF.md
# Coprocessor host register interface

This block is the register and memory window that sits between a host CPU and a small auxiliary processor used as a programmable transfer engine. The host reaches it through a pipelined Wishbone slave port. Through that port the host sees the coprocessor's program memory, a control register that keeps the coprocessor in reset, an interrupt input register, an interrupt output register and sixteen general-purpose 32-bit mailbox registers. The meaning of the mailbox registers is left to the software running on the coprocessor. The coprocessor reaches the same registers through a separate local port that has a one-cycle read latency.

The host address carries a region bit above the program memory index. When the region bit is 0, the access targets the program memory, which sits outside this block behind a synchronous RAM port. The block drives that port only while the coprocessor is held in reset. An access made while the coprocessor runs still completes. When the region bit is 1, the low five address bits select a register. Offset 0 is control, offset 1 is interrupt input, offset 2 is interrupt output, offsets 16 to 31 are the mailbox registers, and every other offset reads zero. The local port uses the same five-bit offsets.

Interrupt sources are never delivered to the coprocessor. Instead, rising edges are captured in the interrupt input register, and the coprocessor software polls that register. The coprocessor raises bits in the interrupt output register, and any set bit drives `irq_out` towards the host.

A three-state machine handles host accesses:
- `HS_IDLE` moves to `HS_EXEC` when `cyc & stb` is seen, and stall is high in that cycle.
- `HS_EXEC` performs the access and always moves to `HS_REPLY`.
- `HS_REPLY` raises ack for one cycle and always returns to `HS_IDLE`.

Top module: `cop_hostif`

## Requirements
- R1: Bit 0 of the control register (register offset 0) drives `cop_rst_n`. It resets to 0, which holds the coprocessor in reset. A host write of 1 releases the coprocessor and a host write of 0 holds it again. Writes to offset 0 from the local port have no effect.
- R2: A host access with `hst_adr[PM_AW]`=0 drives the program memory port only while `cop_rst_n` is 0. A word written there reads back unchanged.
- R3: While `cop_rst_n` is 1, a host program memory access still acks. A read returns zero and a write leaves the memory contents unchanged.
- R4: The sixteen mailbox registers at offsets 16 to 31 reset to zero. A value written through either port reads back through both ports.
- R5: When the host and the local port write the same mailbox register in the same cycle, the register takes the local data.
- R6: The interrupt input register (offset 1, bit i for `irq_src[i]`) sets a bit on a rising edge of its source and holds it while the source stays high. The bit clears when the local port writes 1 to it. Both ports can read the register.
- R7: In the interrupt output register (offset 2), a local write of 1 sets a bit and a host write of 1 clears it. `irq_out` is 1 exactly while any bit is set and is 0 after reset.
- R8: A host clear and a local set of the same interrupt output bit in the same cycle leave the bit set.
- R9: Each host access follows a fixed handshake. Stall is high in the first cycle `cyc & stb` is seen and low in the next cycle. Ack is high for exactly one cycle after that, with the read data on `hst_dat_r`.
- R10: A local read returns its data on `loc_rdat` in the cycle after `loc_req` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cyc | input | 1 | Host bus cycle |
| hst_stb | input | 1 | Host strobe |
| hst_we | input | 1 | Host write enable |
| hst_adr | input | PM_AW+1 | Host word address; top bit selects registers |
| hst_dat_w | input | DATA_W | Host write data |
| hst_dat_r | output | DATA_W | Host read data, valid with ack |
| hst_ack | output | 1 | Host access complete |
| hst_stall | output | 1 | Host request not yet taken |
| loc_req | input | 1 | Local port request |
| loc_we | input | 1 | Local port write enable |
| loc_adr | input | 5 | Local register offset |
| loc_wdat | input | DATA_W | Local write data |
| loc_rdat | output | DATA_W | Local read data, one cycle after request |
| cop_rst_n | output | 1 | Coprocessor reset, low holds it |
| irq_src | input | IRQ_W | System interrupt sources |
| irq_out | output | 1 | Interrupt towards the host |
| pm_en | output | 1 | Program memory enable |
| pm_we | output | 1 | Program memory write |
| pm_adr | output | PM_AW | Program memory word address |
| pm_wdat | output | DATA_W | Program memory write data |
| pm_rdat | input | DATA_W | Program memory read data, one cycle after enable |

## Verification
Two pairs of functions can fall in the same cycle.
- **Mailbox writes:** a host write to a mailbox register and a local write to the same register.
- **Interrupt output bits:** a host clear of an interrupt output bit and a local set of that bit.

The bench provokes each pair by driving the local write during the `HS_EXEC` cycle of a host write, so both take effect on the same clock edge. It then reads the result back through the host port. The mailbox must hold the local data. The interrupt output bit must stay set, and `irq_out` must stay high.

// File: rtl/cop_hostif_pkg.sv
package cop_hostif_pkg;

    localparam int REG_OFS_W = 5;

    localparam logic [REG_OFS_W-1:0] OFS_CTRL   = 5'd0;
    localparam logic [REG_OFS_W-1:0] OFS_IRQIN  = 5'd1;
    localparam logic [REG_OFS_W-1:0] OFS_IRQOUT = 5'd2;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_EXEC  = 2'd1,
        HS_REPLY = 2'd2
    } hs_state_t;

endpackage

// File: rtl/cop_hostif_fsm.sv
module cop_hostif_fsm
    import cop_hostif_pkg::*;
#(
    parameter int PM_AW  = 10,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_cyc,
    input  logic                 hst_stb,
    input  logic                 hst_we,
    input  logic [PM_AW:0]       hst_adr,
    input  logic [DATA_W-1:0]    hst_dat_w,
    output logic                 hst_stall,
    output logic                 hst_ack,
    output logic [DATA_W-1:0]    hst_dat_r,
    input  logic                 cop_held,
    output logic                 reg_wr,
    output logic [REG_OFS_W-1:0] reg_ofs,
    output logic [DATA_W-1:0]    reg_wdat,
    input  logic [DATA_W-1:0]    reg_rdat,
    output logic                 pm_en,
    output logic                 pm_we,
    output logic [PM_AW-1:0]     pm_adr,
    output logic [DATA_W-1:0]    pm_wdat,
    input  logic [DATA_W-1:0]    pm_rdat
);

    hs_state_t          state_q, state_d;
    logic               take;
    logic               rq_we_q, rq_reg_q;
    logic [PM_AW-1:0]   rq_adr_q;
    logic [DATA_W-1:0]  rq_dat_q;
    logic               pm_hit_q;
    logic [DATA_W-1:0]  rdat_q;
    logic               pm_ok;

    assign take  = hst_cyc & hst_stb;
    assign pm_ok = !rq_reg_q && cop_held;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:  if (take) state_d = HS_EXEC;
            HS_EXEC:  state_d = HS_REPLY;
            HS_REPLY: state_d = HS_IDLE;
            default:  state_d = HS_IDLE;
        endcase
    end

    // Request capture and reply data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_we_q  <= 1'b0;
            rq_reg_q <= 1'b0;
            rq_adr_q <= '0;
            rq_dat_q <= '0;
            pm_hit_q <= 1'b0;
            rdat_q   <= '0;
        end else begin
            if (state_q == HS_IDLE && take) begin
                rq_we_q  <= hst_we;
                rq_reg_q <= hst_adr[PM_AW];
                rq_adr_q <= hst_adr[PM_AW-1:0];
                rq_dat_q <= hst_dat_w;
            end
            if (state_q == HS_EXEC) begin
                pm_hit_q <= pm_ok;
                rdat_q   <= rq_reg_q ? reg_rdat : '0;
            end
        end
    end

    assign reg_ofs  = rq_adr_q[REG_OFS_W-1:0];
    assign reg_wdat = rq_dat_q;
    assign pm_adr   = rq_adr_q;
    assign pm_wdat  = rq_dat_q;

    // Outputs
    always_comb begin
        hst_stall = 1'b0;
        hst_ack   = 1'b0;
        hst_dat_r = '0;
        reg_wr    = 1'b0;
        pm_en     = 1'b0;
        pm_we     = 1'b0;
        unique case (state_q)
            HS_IDLE: hst_stall = take;
            HS_EXEC: begin
                pm_en  = pm_ok;
                pm_we  = pm_ok && rq_we_q;
                reg_wr = rq_reg_q && rq_we_q;
            end
            HS_REPLY: begin
                hst_ack   = 1'b1;
                hst_dat_r = pm_hit_q ? pm_rdat : rdat_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cop_hostif_irq.sv
module cop_hostif_irq #(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] irq_src,
    input  logic [IRQ_W-1:0] in_clr,
    input  logic [IRQ_W-1:0] out_set,
    input  logic [IRQ_W-1:0] out_clr,
    output logic [IRQ_W-1:0] irq_in_q,
    output logic [IRQ_W-1:0] irq_out_q,
    output logic             irq_any
);

    logic [IRQ_W-1:0] src_q;
    logic [IRQ_W-1:0] rise;

    assign rise = irq_src & ~src_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= '0;
            irq_in_q  <= '0;
            irq_out_q <= '0;
        end else begin
            src_q     <= irq_src;
            irq_in_q  <= (irq_in_q & ~in_clr) | rise;
            irq_out_q <= (irq_out_q & ~out_clr) | out_set;
        end
    end

    assign irq_any = |irq_out_q;

endmodule

// File: rtl/cop_hostif_gpr.sv
module cop_hostif_gpr #(
    parameter int N_REG  = 16,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         h_we,
    input  logic [$clog2(N_REG)-1:0]     h_idx,
    input  logic [DATA_W-1:0]            h_wdat,
    input  logic                         l_we,
    input  logic [$clog2(N_REG)-1:0]     l_idx,
    input  logic [DATA_W-1:0]            l_wdat,
    output logic [N_REG-1:0][DATA_W-1:0] q
);

    localparam int IW = $clog2(N_REG);

    for (genvar i = 0; i < N_REG; i++) begin : g_reg
        logic [DATA_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          r <= '0;
            else if (l_we && l_idx == IW'(i))    r <= l_wdat;
            else if (h_we && h_idx == IW'(i))    r <= h_wdat;
        end
        assign q[i] = r;
    end

endmodule

// File: rtl/cop_hostif.sv
module cop_hostif
    import cop_hostif_pkg::*;
#(
    parameter int PM_AW  = 10,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 8,
    parameter int N_GPR  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_cyc,
    input  logic                 hst_stb,
    input  logic                 hst_we,
    input  logic [PM_AW:0]       hst_adr,
    input  logic [DATA_W-1:0]    hst_dat_w,
    output logic [DATA_W-1:0]    hst_dat_r,
    output logic                 hst_ack,
    output logic                 hst_stall,
    input  logic                 loc_req,
    input  logic                 loc_we,
    input  logic [REG_OFS_W-1:0] loc_adr,
    input  logic [DATA_W-1:0]    loc_wdat,
    output logic [DATA_W-1:0]    loc_rdat,
    output logic                 cop_rst_n,
    input  logic [IRQ_W-1:0]     irq_src,
    output logic                 irq_out,
    output logic                 pm_en,
    output logic                 pm_we,
    output logic [PM_AW-1:0]     pm_adr,
    output logic [DATA_W-1:0]    pm_wdat,
    input  logic [DATA_W-1:0]    pm_rdat
);

    localparam int GPR_IW = $clog2(N_GPR);

    logic                         run_q;
    logic                         reg_wr;
    logic [REG_OFS_W-1:0]         reg_ofs;
    logic [DATA_W-1:0]            reg_wdat;
    logic [DATA_W-1:0]            reg_rdat;
    logic                         loc_wr;
    logic [IRQ_W-1:0]             in_clr, out_set, out_clr;
    logic [IRQ_W-1:0]             irq_in_q, irq_out_q;
    logic [N_GPR-1:0][DATA_W-1:0] gpr_q;

    function automatic logic [DATA_W-1:0] rd_mux(
        input logic [REG_OFS_W-1:0]         ofs,
        input logic                         run,
        input logic [IRQ_W-1:0]             iin,
        input logic [IRQ_W-1:0]             iout,
        input logic [N_GPR-1:0][DATA_W-1:0] g
    );
        logic [DATA_W-1:0] v;
        v = '0;
        if (ofs[REG_OFS_W-1])      v = g[ofs[GPR_IW-1:0]];
        else if (ofs == OFS_CTRL)  v = DATA_W'(run);
        else if (ofs == OFS_IRQIN) v = DATA_W'(iin);
        else if (ofs == OFS_IRQOUT) v = DATA_W'(iout);
        return v;
    endfunction

    cop_hostif_fsm #(.PM_AW(PM_AW), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hst_cyc   (hst_cyc),
        .hst_stb   (hst_stb),
        .hst_we    (hst_we),
        .hst_adr   (hst_adr),
        .hst_dat_w (hst_dat_w),
        .hst_stall (hst_stall),
        .hst_ack   (hst_ack),
        .hst_dat_r (hst_dat_r),
        .cop_held  (!run_q),
        .reg_wr    (reg_wr),
        .reg_ofs   (reg_ofs),
        .reg_wdat  (reg_wdat),
        .reg_rdat  (reg_rdat),
        .pm_en     (pm_en),
        .pm_we     (pm_we),
        .pm_adr    (pm_adr),
        .pm_wdat   (pm_wdat),
        .pm_rdat   (pm_rdat)
    );

    // Control register: host-only write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            run_q <= 1'b0;
        else if (reg_wr && reg_ofs == OFS_CTRL) run_q <= reg_wdat[0];
    end
    assign cop_rst_n = run_q;

    assign loc_wr  = loc_req && loc_we;
    assign in_clr  = (loc_wr && loc_adr == OFS_IRQIN)  ? loc_wdat[IRQ_W-1:0] : '0;
    assign out_set = (loc_wr && loc_adr == OFS_IRQOUT) ? loc_wdat[IRQ_W-1:0] : '0;
    assign out_clr = (reg_wr && reg_ofs == OFS_IRQOUT) ? reg_wdat[IRQ_W-1:0] : '0;

    cop_hostif_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .in_clr    (in_clr),
        .out_set   (out_set),
        .out_clr   (out_clr),
        .irq_in_q  (irq_in_q),
        .irq_out_q (irq_out_q),
        .irq_any   (irq_out)
    );

    cop_hostif_gpr #(.N_REG(N_GPR), .DATA_W(DATA_W)) u_gpr (
        .clk    (clk),
        .rst_n  (rst_n),
        .h_we   (reg_wr && reg_ofs[REG_OFS_W-1]),
        .h_idx  (reg_ofs[GPR_IW-1:0]),
        .h_wdat (reg_wdat),
        .l_we   (loc_wr && loc_adr[REG_OFS_W-1]),
        .l_idx  (loc_adr[GPR_IW-1:0]),
        .l_wdat (loc_wdat),
        .q      (gpr_q)
    );

    always_comb reg_rdat = rd_mux(reg_ofs, run_q, irq_in_q, irq_out_q, gpr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                loc_rdat <= '0;
        else if (loc_req && !loc_we) loc_rdat <= rd_mux(loc_adr, run_q, irq_in_q, irq_out_q, gpr_q);
    end

endmodule

// File: rtl/cop_hostif_chk.sv
module cop_hostif_chk #(
    parameter int IRQ_W  = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_stall,
    input logic              hst_ack,
    input logic              pm_en,
    input logic              cop_rst_n,
    input logic              loc_req,
    input logic              loc_we,
    input logic [4:0]        loc_adr,
    input logic [DATA_W-1:0] loc_wdat,
    input logic              irq_out
);

    // R9
    stall_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_stall |=> (!hst_stall && !hst_ack) ##1 hst_ack);

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_ack |=> !hst_ack);

    // R2
    pm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_en |-> !cop_rst_n);

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_req && loc_we && loc_adr == 5'd2 && loc_wdat[IRQ_W-1:0] != '0) |=> irq_out);

endmodule

bind cop_hostif cop_hostif_chk #(.IRQ_W(IRQ_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_stall (hst_stall),
    .hst_ack   (hst_ack),
    .pm_en     (pm_en),
    .cop_rst_n (cop_rst_n),
    .loc_req   (loc_req),
    .loc_we    (loc_we),
    .loc_adr   (loc_adr),
    .loc_wdat  (loc_wdat),
    .irq_out   (irq_out)
);

// File: tb/cop_hostif_tb.sv
module cop_hostif_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_cyc = 1'b0, hst_stb = 1'b0, hst_we = 1'b0;
    logic [10:0] hst_adr = '0;
    logic [31:0] hst_dat_w = '0;
    logic [31:0] hst_dat_r;
    logic        hst_ack, hst_stall;
    logic        loc_req = 1'b0, loc_we = 1'b0;
    logic [4:0]  loc_adr = '0;
    logic [31:0] loc_wdat = '0;
    logic [31:0] loc_rdat;
    logic        cop_rst_n;
    logic [7:0]  irq_src = '0;
    logic        irq_out;
    logic        pm_en, pm_we;
    logic [9:0]  pm_adr;
    logic [31:0] pm_wdat;
    logic [31:0] pm_rdat;
    logic [31:0] pm_mem [0:1023];

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (pm_en) begin
            if (pm_we) pm_mem[pm_adr] <= pm_wdat;
            pm_rdat <= pm_mem[pm_adr];
        end
    end

    cop_hostif u_dut (
        .clk(clk), .rst_n(rst_n),
        .hst_cyc(hst_cyc), .hst_stb(hst_stb), .hst_we(hst_we), .hst_adr(hst_adr),
        .hst_dat_w(hst_dat_w), .hst_dat_r(hst_dat_r), .hst_ack(hst_ack), .hst_stall(hst_stall),
        .loc_req(loc_req), .loc_we(loc_we), .loc_adr(loc_adr), .loc_wdat(loc_wdat),
        .loc_rdat(loc_rdat), .cop_rst_n(cop_rst_n), .irq_src(irq_src), .irq_out(irq_out),
        .pm_en(pm_en), .pm_we(pm_we), .pm_adr(pm_adr), .pm_wdat(pm_wdat), .pm_rdat(pm_rdat)
    );

    function automatic logic [10:0] ra(input logic [4:0] ofs);
        return {1'b1, 5'd0, ofs};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_xfer(input logic we, input logic [10:0] adr, input logic [31:0] wd,
                             output logic [31:0] rdat);
        @(negedge clk);
        hst_cyc = 1'b1; hst_stb = 1'b1; hst_we = we; hst_adr = adr; hst_dat_w = wd;
        #1 chk("R9 stall on first cycle", 32'(hst_stall), 32'd1);
        @(negedge clk);
        chk("R9 stall released", 32'(hst_stall), 32'd0);
        chk("R9 no early ack", 32'(hst_ack), 32'd0);
        hst_stb = 1'b0;
        @(negedge clk);
        chk("R9 ack after accept", 32'(hst_ack), 32'd1);
        rdat = hst_dat_r;
        hst_cyc = 1'b0; hst_we = 1'b0;
    endtask

    task automatic host_wr(input logic [10:0] adr, input logic [31:0] wd);
        logic [31:0] dummy;
        host_xfer(1'b1, adr, wd, dummy);
    endtask

    task automatic loc_wr(input logic [4:0] adr, input logic [31:0] wd);
        @(negedge clk);
        loc_req = 1'b1; loc_we = 1'b1; loc_adr = adr; loc_wdat = wd;
        @(negedge clk);
        loc_req = 1'b0; loc_we = 1'b0;
    endtask

    task automatic loc_rd(input logic [4:0] adr, output logic [31:0] rdat);
        @(negedge clk);
        loc_req = 1'b1; loc_we = 1'b0; loc_adr = adr;
        @(negedge clk);
        rdat = loc_rdat;
        loc_req = 1'b0;
    endtask

    // Host write and local write landing on the same clock edge
    task automatic collide(input logic [4:0] ofs, input logic [31:0] hd, input logic [31:0] ld);
        @(negedge clk);
        hst_cyc = 1'b1; hst_stb = 1'b1; hst_we = 1'b1; hst_adr = ra(ofs); hst_dat_w = hd;
        @(negedge clk);
        hst_stb = 1'b0;
        loc_req = 1'b1; loc_we = 1'b1; loc_adr = ofs; loc_wdat = ld;
        @(negedge clk);
        chk("R9 ack in collision", 32'(hst_ack), 32'd1);
        loc_req = 1'b0; loc_we = 1'b0; hst_cyc = 1'b0; hst_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset holds coprocessor", 32'(cop_rst_n), 32'd0);
        chk("R7 irq_out low after reset", 32'(irq_out), 32'd0);
        chk("R9 no ack after reset", 32'(hst_ack), 32'd0);
        host_xfer(1'b0, ra(5'd23), 32'd0, rd);
        chk("R4 mailbox reset value", rd, 32'd0);
    endtask

    task automatic t_gpr();
        host_wr(ra(5'd16), 32'h1122_3344);
        host_xfer(1'b0, ra(5'd16), 32'd0, rd);
        chk("R4 host write host read", rd, 32'h1122_3344);
        loc_rd(5'd16, rd);
        chk("R10 R4 local read of host value", rd, 32'h1122_3344);
        loc_wr(5'd31, 32'hCAFE_F00D);
        host_xfer(1'b0, ra(5'd31), 32'd0, rd);
        chk("R4 local write host read", rd, 32'hCAFE_F00D);
        host_xfer(1'b0, ra(5'd16), 32'd0, rd);
        chk("R4 neighbour untouched", rd, 32'h1122_3344);
    endtask

    task automatic t_collide();
        collide(5'd21, 32'hAAAA_0000, 32'h5555_FFFF);
        host_xfer(1'b0, ra(5'd21), 32'd0, rd);
        chk("R5 local wins same-cycle write", rd, 32'h5555_FFFF);
    endtask

    task automatic t_pm_held();
        host_wr(11'd3, 32'hDEAD_BEEF);
        host_wr(11'd1023, 32'h0F0F_0F0F);
        host_xfer(1'b0, 11'd3, 32'd0, rd);
        chk("R2 program word 3", rd, 32'hDEAD_BEEF);
        host_xfer(1'b0, 11'd1023, 32'd0, rd);
        chk("R2 program word 1023", rd, 32'h0F0F_0F0F);
    endtask

    task automatic t_ctrl_run();
        host_wr(ra(5'd0), 32'd1);
        chk("R1 release by host", 32'(cop_rst_n), 32'd1);
        host_xfer(1'b0, ra(5'd0), 32'd0, rd);
        chk("R1 control reads 1", rd, 32'd1);
        loc_wr(5'd0, 32'd0);
        chk("R1 local write ignored", 32'(cop_rst_n), 32'd1);
    endtask

    task automatic t_pm_running();
        host_xfer(1'b0, 11'd3, 32'd0, rd);
        chk("R3 read while running", rd, 32'd0);
        host_wr(11'd3, 32'h1234_5678);
        host_wr(ra(5'd0), 32'd0);
        chk("R1 hold by host", 32'(cop_rst_n), 32'd0);
        host_xfer(1'b0, 11'd3, 32'd0, rd);
        chk("R3 write while running discarded", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_irq_in();
        @(negedge clk); irq_src = 8'h04;
        @(negedge clk);
        loc_rd(5'd1, rd);
        chk("R6 edge latched", rd, 32'h4);
        loc_wr(5'd1, 32'h4);
        loc_rd(5'd1, rd);
        chk("R6 cleared while source high", rd, 32'h0);
        @(negedge clk); irq_src = 8'h00;
        @(negedge clk); irq_src = 8'h84;
        @(negedge clk);
        host_xfer(1'b0, ra(5'd1), 32'd0, rd);
        chk("R6 host sees new edges", rd, 32'h84);
        irq_src = 8'h00;
    endtask

    task automatic t_irq_out();
        loc_wr(5'd2, 32'h5);
        chk("R7 set raises irq_out", 32'(irq_out), 32'd1);
        host_wr(ra(5'd2), 32'h1);
        host_xfer(1'b0, ra(5'd2), 32'd0, rd);
        chk("R7 partial clear", rd, 32'h4);
        chk("R7 irq_out still high", 32'(irq_out), 32'd1);
        host_wr(ra(5'd2), 32'h4);
        chk("R7 irq_out low after full clear", 32'(irq_out), 32'd0);
        collide(5'd2, 32'h2, 32'h2);
        host_xfer(1'b0, ra(5'd2), 32'd0, rd);
        chk("R8 set wins over clear", rd, 32'h2);
        chk("R8 irq_out stays high", 32'(irq_out), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_gpr();
        t_collide();
        t_pm_held();
        t_ctrl_run();
        t_pm_running();
        t_irq_in();
        t_irq_out();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule